// File: doc/BRIEF.md
# Receiver-acknowledged multi-cycle path synchronizer

This block carries one multi-bit word at a time from a source clock domain to an unrelated destination clock domain. The source offers a word with a valid/ready handshake. The accepted word is captured into a source-side holding register, and a request toggle crosses into the destination through a two-flop synchronizer. The word itself is not synchronized. It stays still on the holding register for as many destination cycles as the crossing needs.

In the destination, a two-state controller raises `dst_valid` once it sees the request edge. It keeps `dst_valid` high until the receiving logic pulses `dst_load`. That pulse loads the destination data register and flips an acknowledge toggle. The toggle crosses back through two source-clock flops, and its edge re-arms `src_ready`.

Back-pressure works as follows. The source may hold `src_valid` high for as long as it likes, but a word transfers only on a source edge where both `src_valid` and `src_ready` are high. In the destination, `dst_load` acts as the ready of the output side and may be withheld indefinitely. The acknowledge does not return until the receiver has loaded the word, so the source stalls for as long as the receiver does.

Top module: `mcp_ack_sync`

## Requirements
- R1: While either reset is asserted, and after it is released with no traffic, `src_ready` is 1, `dst_valid` is 0 and `dst_data` is 0.
- R2: A word is accepted on a source edge where `src_valid` and `src_ready` are both 1. After that edge `src_ready` is 0.
- R3: After a word is accepted, `dst_valid` rises within four destination clock cycles.
- R4: Once high, `dst_valid` stays high until a destination edge samples `dst_load` high.
- R5: A destination edge with `dst_valid` and `dst_load` both high loads the accepted word into `dst_data`, and `dst_valid` is 0 after it. At any other edge `dst_data` keeps its value.
- R6: `dst_load` sampled while `dst_valid` is 0 has no effect: `dst_data` is unchanged, and no acknowledge is produced, so `src_ready` does not change.
- R7: `src_ready` stays 0 until the load of the pending word. It returns to 1 within five source clock cycles after that load.
- R8: Values on `src_valid` and `src_data` while `src_ready` is 0 are ignored. The word delivered is the one accepted earlier.
- R9: Every accepted word appears on `dst_data` exactly once and in order. After a load, `dst_valid` stays 0 until a new word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock |
| src_rst_n | input | 1 | Source asynchronous reset, active low |
| src_valid | input | 1 | Source offers a word |
| src_data | input | DATA_W | Word offered by the source |
| src_ready | output | 1 | Block can take a word |
| dst_clk | input | 1 | Destination clock |
| dst_rst_n | input | 1 | Destination asynchronous reset, active low |
| dst_valid | output | 1 | A word is waiting to be loaded |
| dst_load | input | 1 | Receiver loads the waiting word |
| dst_data | output | DATA_W | Destination data register |

## Verification
The hardest situation to reach is a receiver that holds off for a long time while the source keeps pushing new values. In that case the acknowledge must stay withheld and the held word must not be disturbed. The stimulus table gives each word its own load delay, up to many destination cycles. During that wait the bench checks on every cycle that `src_ready` stays low and `dst_data` stays still. Directed tests then drive fresh data with `src_valid` high while `src_ready` is low, and pulse `dst_load` while nothing is pending, before showing that the delivered word is still the original.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_VALID = 1'b1
  } dst_state_e;
endpackage

// File: rtl/mcp_sync.sv
module mcp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mcp_src_ctl.sv
module mcp_src_ctl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic [DATA_W-1:0] hold_data,
  output logic              req_tgl,
  input  logic              ack_tgl_s
);
  logic ack_prev;
  logic take;
  logic ack_edge;

  assign take     = src_valid && src_ready;
  assign ack_edge = ack_tgl_s ^ ack_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ready <= 1'b1;
      hold_data <= '0;
      req_tgl   <= 1'b0;
      ack_prev  <= 1'b0;
    end else begin
      ack_prev <= ack_tgl_s;
      if (take) begin
        src_ready <= 1'b0;
        hold_data <= src_data;
        req_tgl   <= ~req_tgl;
      end else if (ack_edge) begin
        src_ready <= 1'b1;
      end
    end
  end

  // R2: accepted word drops ready
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |=> !src_ready);
  // R7: ready stays low without a returned acknowledge
  p_ready_waits_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_ready && (ack_tgl_s == ack_prev)) |=> !src_ready);
  // R8: held word only changes on acceptance
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_valid && src_ready) |=> $stable(hold_data));
endmodule

// File: rtl/mcp_dst_ctl.sv
module mcp_dst_ctl
  import mcp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl_s,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              dst_load,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data,
  output logic              ack_tgl
);
  dst_state_e state;
  logic       req_prev;
  logic       req_edge;
  logic       do_load;

  assign req_edge  = req_tgl_s ^ req_prev;
  assign dst_valid = (state == ST_VALID);
  assign do_load   = dst_valid && dst_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      req_prev <= 1'b0;
      dst_data <= '0;
      ack_tgl  <= 1'b0;
    end else begin
      req_prev <= req_tgl_s;
      case (state)
        ST_IDLE:  if (req_edge) state <= ST_VALID;
        ST_VALID: if (dst_load) begin
          state    <= ST_IDLE;
          dst_data <= hold_data;
          ack_tgl  <= ~ack_tgl;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R4: valid held until load
  p_valid_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_load) |=> dst_valid);
  // R5: load clears valid
  p_valid_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> !dst_valid);
  // R6: data register untouched without a qualified load
  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !do_load |=> $stable(dst_data));
  // R6: acknowledge only follows a qualified load
  p_ack_only_on_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !do_load |=> $stable(ack_tgl));
endmodule

// File: rtl/mcp_ack_sync.sv
module mcp_ack_sync #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_valid,
  input  logic              dst_load,
  output logic [DATA_W-1:0] dst_data
);
  logic [DATA_W-1:0] hold_data;
  logic              req_tgl, req_tgl_s;
  logic              ack_tgl, ack_tgl_s;

  mcp_src_ctl #(.DATA_W(DATA_W)) src_i (
    .clk(src_clk), .rst_n(src_rst_n), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .hold_data(hold_data), .req_tgl(req_tgl), .ack_tgl_s(ack_tgl_s)
  );

  mcp_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(req_tgl), .q(req_tgl_s)
  );

  mcp_dst_ctl #(.DATA_W(DATA_W)) dst_i (
    .clk(dst_clk), .rst_n(dst_rst_n), .req_tgl_s(req_tgl_s), .hold_data(hold_data),
    .dst_load(dst_load), .dst_valid(dst_valid), .dst_data(dst_data), .ack_tgl(ack_tgl)
  );

  mcp_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
    .clk(src_clk), .rst_n(src_rst_n), .d(ack_tgl), .q(ack_tgl_s)
  );
endmodule

// File: tb/mcp_ack_sync_tb_top.sv
module mcp_ack_sync_tb_top;
  localparam int DW = 8;

  typedef struct packed {
    logic [7:0] word;
    logic [4:0] gap;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'hA5, 5'd0}, '{8'h3C, 5'd1}, '{8'hFF, 5'd7}, '{8'h00, 5'd2},
    '{8'h81, 5'd20}, '{8'h5A, 5'd3}, '{8'h7E, 5'd12}, '{8'h19, 5'd5}
  };

  logic src_clk = 0, dst_clk = 0;
  logic src_rst_n = 0, dst_rst_n = 0;
  logic src_valid = 0, dst_load = 0;
  logic [DW-1:0] src_data = '0;
  logic src_ready, dst_valid;
  logic [DW-1:0] dst_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 src_clk = ~src_clk;
  always #7  dst_clk = ~dst_clk;

  mcp_ack_sync #(.DATA_W(DW)) dut_i (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_valid(dst_valid),
    .dst_load(dst_load), .dst_data(dst_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] w);
    @(negedge src_clk);
    src_valid = 1; src_data = w;
    @(negedge src_clk);
    src_valid = 0;
    chk("R2 ready low after accept", src_ready, 0);
  endtask

  task automatic wait_valid();
    int n = 0;
    while (!dst_valid && n < 8) begin @(negedge dst_clk); n++; end
    chk("R3 valid within 4 dst cycles", (n <= 4), 1);
  endtask

  task automatic load_now();
    @(negedge dst_clk); dst_load = 1;
    @(negedge dst_clk); dst_load = 0;
  endtask

  task automatic wait_ready();
    int n = 0;
    @(negedge src_clk);
    while (!src_ready && n < 10) begin @(negedge src_clk); n++; end
    chk("R7 ready back within 5 src cycles", (n <= 5), 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] prev;
    // R1 during reset
    #35;
    chk("R1 ready in reset", src_ready, 1);
    chk("R1 valid in reset", dst_valid, 0);
    chk("R1 data in reset", dst_data, 0);
    @(negedge src_clk); src_rst_n = 1;
    @(negedge dst_clk); dst_rst_n = 1;
    repeat (3) @(negedge dst_clk);
    chk("R1 ready after reset", src_ready, 1);
    chk("R1 valid after reset", dst_valid, 0);

    // table walk: R2 R3 R4 R5 R7 R9
    for (int i = 0; i < 8; i++) begin
      prev = dst_data;
      send(VECS[i].word);
      wait_valid();
      for (int k = 0; k < int'(VECS[i].gap); k++) begin
        @(negedge dst_clk);
        chk("R4 valid held", dst_valid, 1);
        chk("R7 ready low before load", src_ready, 0);
        chk("R5 data held before load", dst_data, prev);
      end
      load_now();
      chk("R5 data loaded", dst_data, VECS[i].word);
      chk("R5 valid cleared", dst_valid, 0);
      wait_ready();
      @(negedge dst_clk);
      chk("R9 no duplicate valid", dst_valid, 0);
      chk("R9 word delivered once", dst_data, VECS[i].word);
    end

    // R6: load while idle ignored
    prev = dst_data;
    repeat (4) begin
      @(negedge dst_clk); dst_load = 1;
    end
    @(negedge dst_clk); dst_load = 0;
    repeat (8) @(negedge src_clk);
    chk("R6 data unchanged", dst_data, prev);
    chk("R6 valid stays low", dst_valid, 0);
    chk("R6 ready unchanged", src_ready, 1);

    // R8: source pushes while busy
    send(8'hC3);
    @(negedge src_clk); src_valid = 1; src_data = 8'h11;
    repeat (6) @(negedge src_clk);
    src_data = 8'h22;
    wait_valid();
    repeat (4) @(negedge src_clk);
    chk("R8 ready still low", src_ready, 0);
    load_now();
    chk("R8 original word delivered", dst_data, 8'hC3);
    @(negedge src_clk); src_valid = 0;
    // the accepted extra word, if any, came from a later edge with ready high
    wait_ready();
    repeat (2) @(negedge dst_clk);
    chk("R9 no spurious valid", dst_valid, 0);

    // R9: back-to-back words in order
    for (int j = 0; j < 3; j++) begin
      send(8'h40 + 8'(j));
      wait_valid();
      load_now();
      chk("R9 in order", dst_data, 8'h40 + 8'(j));
      wait_ready();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule